// File: doc/BRIEF.md
# Dual Store Queue Burst Writer

This block is a write-combining buffer with two line-sized queues of 32 bytes each. The queues sit behind a fixed address window. An ordinary word store that lands in the window goes into a queue in one cycle and does not touch external memory. A prefetch command aimed at the window empties the chosen queue to external memory as one eight-word burst on a simple valid/ready beat interface.

Every access in the window passes a permission check before it is performed. When address translation is off, the current privilege level and a configuration bit that opens the queues to user mode together decide the result. When translation is on, the page-protection verdict arrives on an input and decides alone. A refused access leaves all state unchanged and produces a one-cycle error pulse. Accesses outside the window are ignored.

Top module: `sq_burst_writer`

## Requirements
- R1: After reset no burst is in progress, `bus_valid`, `req_stall` and `addr_err` are low, both queues hold all-zero words, and both prefix registers are zero.
- R2: Only requests whose address lies in 0xE000_0000..0xE3FF_FFFF (address bits [31:26] equal to 6'b111000) are acted on. Any other request, store or prefetch, changes no queue, starts no burst, never stalls and raises no error.
- R3: A permitted, unstalled store (`req_is_flush`=0) in the window writes `req_wdata` into the queue chosen by address bit 5, at the word chosen by bits [4:2], on that clock edge. It causes no bus activity.
- R4: A permitted, unstalled prefetch (`req_is_flush`=1) in the window starts a burst from the queue chosen by bit 5. `bus_valid` rises in the next cycle. The eight words go out in ascending index order, and `bus_last` is high only with the eighth word.
- R5: A beat completes only in a cycle where `bus_valid` and `bus_ready` are both high. While `bus_ready` is low, `bus_data`, `bus_addr` and `bus_last` hold their values. `bus_valid` falls in the cycle after the last beat completes.
- R6: `bus_addr` for a burst is the concatenation of the chosen queue's 6-bit prefix register, prefetch address bits [25:5], and five zero bits. The prefix is the value held when the prefetch is accepted. A prefix register is written with `pfx_data` at a clock edge where `pfx_we` is high, and `pfx_sel` picks the queue.
- R7: While a burst runs, a permitted store to the other queue is accepted at once. A permitted store to the queue being sent, or any permitted prefetch, raises `req_stall` in the same cycle and is not performed. It is accepted in the first cycle after the last beat.
- R8: An access in the window is permitted when `xlat_en`=0 and either `req_priv`=1 or `cfg_user_ok`=1. It is also permitted when `xlat_en`=1 and `page_ok`=1. In all other cases it is refused.
- R9: A refused access changes no queue, starts no burst and does not stall. `addr_err` is high in the cycle after each refused access, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_is_flush | input | 1 | 1 = prefetch (flush), 0 = store |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Store data word |
| req_priv | input | 1 | Requester runs in privileged mode |
| xlat_en | input | 1 | Address translation enabled |
| cfg_user_ok | input | 1 | Queues open to user mode when translation is off |
| page_ok | input | 1 | Page protection allows the access (translation on) |
| req_stall | output | 1 | Request not taken this cycle; hold and retry |
| addr_err | output | 1 | One-cycle pulse after a refused access |
| pfx_we | input | 1 | Prefix register write enable |
| pfx_sel | input | 1 | Prefix register select (queue 0/1) |
| pfx_data | input | 6 | Prefix register write value |
| bus_valid | output | 1 | Burst beat valid |
| bus_ready | input | 1 | Memory side accepts the beat |
| bus_addr | output | 32 | Burst base address, line aligned |
| bus_data | output | 32 | Current beat data |
| bus_last | output | 1 | Final beat of the burst |

## Verification
The assertions check the bus contract on every cycle: data, address and last flag are held while the memory side is not ready, bursts have no gaps, the address is line aligned, and the valid signal drops after the last beat. They also check that every error pulse follows a refused in-window access, and that stalls and errors never come from out-of-window traffic. The queue contents, the word order of each burst, the composed external address, the prefix timing, and which queue stays writable during a flush are only visible through the bench's reference model. That model runs through scenarios with irregular ready patterns, mixed privilege settings, and stores and prefetches that overlap a running burst.

// File: rtl/sq_burst_writer.sv
module sq_burst_writer #(
  parameter int          TAG_W   = 6,
  parameter logic [TAG_W-1:0] WIN_TAG = 6'b111000,
  parameter int          LINE_B  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_flush,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_priv,
  input  logic              xlat_en,
  input  logic              cfg_user_ok,
  input  logic              page_ok,
  output logic              req_stall,
  output logic              addr_err,
  input  logic              pfx_we,
  input  logic              pfx_sel,
  input  logic [TAG_W-1:0]  pfx_data,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [31:0]       bus_addr,
  output logic [31:0]       bus_data,
  output logic              bus_last
);
  localparam int WORDS = LINE_B / 4;
  localparam int OFF_W = $clog2(LINE_B);
  localparam int WI_W  = $clog2(WORDS);

  logic [1:0][WORDS-1:0][31:0] qmem;
  logic [1:0][TAG_W-1:0]       pfx;
  logic                        busy, fq;
  logic [WI_W-1:0]             cnt;
  logic [31:0]                 base;

  logic in_win, allowed, hit, sel, do_store, do_flush, beat, at_last;
  logic [WI_W-1:0] widx;

  assign in_win   = req_addr[31:32-TAG_W] == WIN_TAG;
  assign allowed  = xlat_en ? page_ok : (req_priv | cfg_user_ok);
  assign hit      = req_valid & in_win;
  assign sel      = req_addr[OFF_W];
  assign widx     = req_addr[OFF_W-1:2];
  assign req_stall = hit & allowed & busy & (req_is_flush | (sel == fq));
  assign do_store = hit & allowed & ~req_is_flush & ~req_stall;
  assign do_flush = hit & allowed & req_is_flush & ~req_stall;
  assign at_last  = cnt == WI_W'(WORDS - 1);
  assign beat     = busy & bus_ready;

  assign bus_valid = busy;
  assign bus_addr  = base;
  assign bus_data  = qmem[fq][cnt];
  assign bus_last  = busy & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qmem     <= '0;
      pfx      <= '0;
      busy     <= 1'b0;
      fq       <= 1'b0;
      cnt      <= '0;
      base     <= '0;
      addr_err <= 1'b0;
    end else begin
      addr_err <= hit & ~allowed;
      if (pfx_we) pfx[pfx_sel] <= pfx_data;
      if (do_store) qmem[sel][widx] <= req_wdata;
      if (do_flush) begin
        busy <= 1'b1;
        fq   <= sel;
        cnt  <= '0;
        base <= {pfx[sel], req_addr[31-TAG_W:OFF_W], {OFF_W{1'b0}}};
      end else if (beat) begin
        cnt <= cnt + 1'b1;
        if (at_last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sq_burst_writer_chk.sv
module sq_burst_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_priv,
  input logic        xlat_en,
  input logic        cfg_user_ok,
  input logic        page_ok,
  input logic        req_stall,
  input logic        addr_err,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_data,
  input logic        bus_last
);
  logic win, perm;
  assign win  = req_addr[31:26] == 6'b111000;
  assign perm = xlat_en ? page_ok : (req_priv | cfg_user_ok);

  a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_data) && $stable(bus_addr) && $stable(bus_last));
  a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_last |=> bus_valid && $stable(bus_addr));
  a_r5_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_last |=> !bus_valid);
  a_r6_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_addr[4:0] == 5'd0);
  a_r4_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    bus_last |-> bus_valid);
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> $past(req_valid && win && !perm));
  a_r9_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && win && !perm |=> addr_err);
  a_r2_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !win |-> !req_stall);
  a_r7_stall_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |-> bus_valid && req_valid && perm);
endmodule

bind sq_burst_writer sq_burst_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_priv(req_priv), .xlat_en(xlat_en), .cfg_user_ok(cfg_user_ok), .page_ok(page_ok),
  .req_stall(req_stall), .addr_err(addr_err), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_addr(bus_addr), .bus_data(bus_data), .bus_last(bus_last)
);

// File: tb/sq_burst_writer_tb.sv
module sq_burst_writer_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_is_flush = 0, req_priv = 1, xlat_en = 0, cfg_user_ok = 0, page_ok = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic pfx_we = 0, pfx_sel = 0, bus_ready = 1;
  logic [5:0] pfx_data = 0;
  logic req_stall, addr_err, bus_valid, bus_last;
  logic [31:0] bus_addr, bus_data;

  always #2.5 clk = ~clk;

  sq_burst_writer u_dut (.*);

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] m_q [2][8];
  logic [5:0]  m_pfx [2];
  logic        m_busy = 0, m_fq = 0, m_err = 0, m_stall = 0;
  int          m_cnt = 0;
  logic [31:0] m_base = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          rdy_mode = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step();
    logic hit, perm, sel, dst, dfl, bt;
    #1;
    hit  = req_valid && req_addr[31:26] == 6'b111000;
    perm = xlat_en ? page_ok : (req_priv || cfg_user_ok);
    sel  = req_addr[5];
    m_stall = hit && perm && m_busy && (req_is_flush || sel == m_fq);
    dst = hit && perm && !req_is_flush && !m_stall;
    dfl = hit && perm && req_is_flush && !m_stall;
    bt  = m_busy && bus_ready;
    chk(req_stall == m_stall, "R7 stall", {31'd0, req_stall}, {31'd0, m_stall});
    chk(addr_err == m_err, "R9 addr_err", {31'd0, addr_err}, {31'd0, m_err});
    chk(bus_valid == m_busy, "R4 bus_valid", {31'd0, bus_valid}, {31'd0, m_busy});
    if (m_busy) begin
      chk(bus_data == m_q[m_fq][m_cnt], "R4 bus_data order", bus_data, m_q[m_fq][m_cnt]);
      chk(bus_last == (m_cnt == 7), "R5 bus_last", {31'd0, bus_last}, {31'd0, m_cnt == 7});
      chk(bus_addr == m_base, "R6 bus_addr", bus_addr, m_base);
    end
    @(posedge clk);
    if (dfl) begin
      m_busy = 1; m_fq = sel; m_cnt = 0;
      m_base = {m_pfx[sel], req_addr[25:5], 5'd0};
    end else if (bt) begin
      if (m_cnt == 7) m_busy = 0;
      m_cnt = (m_cnt + 1) % 8;
    end
    if (pfx_we) m_pfx[pfx_sel] = pfx_data;
    if (dst) m_q[sel][req_addr[4:2]] = req_wdata;
    m_err = hit && !perm;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (lfsr[0] | lfsr[3]) : lfsr[0] & lfsr[5];
  endtask

  task automatic access(input logic fl, input logic [31:0] a, input logic [31:0] d);
    req_valid = 1; req_is_flush = fl; req_addr = a; req_wdata = d;
    for (int i = 0; i < 200; i++) begin
      step();
      if (!m_stall) break;
    end
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_pfx(input logic s, input logic [5:0] v);
    pfx_we = 1; pfx_sel = s; pfx_data = v;
    step();
    pfx_we = 0;
  endtask

  initial begin
    for (int q = 0; q < 2; q++) begin
      m_pfx[q] = 0;
      for (int w = 0; w < 8; w++) m_q[q][w] = 0;
    end
    repeat (3) @(negedge clk);
    chk(bus_valid == 0 && addr_err == 0 && req_stall == 0, "R1 reset outputs", {29'd0, bus_valid, addr_err, req_stall}, 32'd0);
    rst_n = 1;
    // R1: flush queue 0 straight after reset shows zero contents and zero prefix
    access(1, 32'hE000_0000, 0);
    idle(10);
    // R3: fill both queues
    for (int w = 0; w < 8; w++) access(0, 32'hE000_0000 | (w << 2), 32'h1000_0000 + w * 32'h111);
    for (int w = 7; w >= 0; w--) access(0, 32'hE000_0020 | (w << 2), 32'h2000_0000 + w * 32'h0A0B);
    // R2: out-of-window stores and prefetch have no effect
    access(0, 32'hE400_0000, 32'hDEAD_BEEF);
    access(0, 32'hDFFF_FFE0, 32'hDEAD_BEEF);
    access(1, 32'hE400_0020, 0);
    idle(3);
    chk(bus_valid == 0, "R2 no burst outside window", {31'd0, bus_valid}, 32'd0);
    // R6: prefixes, then flush queue 0 with irregular ready
    set_pfx(0, 6'h15);
    set_pfx(1, 6'h2A);
    rdy_mode = 1;
    access(1, 32'hE123_4540, 0);
    // R7: other queue writable, same queue and flush stall
    access(0, 32'hE000_0024, 32'h3333_0001);
    access(0, 32'hE000_0008, 32'h4444_0002);
    access(1, 32'hE3FF_FFE0, 0);
    idle(20);
    rdy_mode = 2;
    access(1, 32'hE000_0000, 0);
    idle(40);
    rdy_mode = 0;
    // R8/R9: permission cases
    req_priv = 0; cfg_user_ok = 0; xlat_en = 0;
    access(0, 32'hE000_0000, 32'hBAD0_0001);
    access(0, 32'hE000_0004, 32'hBAD0_0002);
    access(1, 32'hE000_0020, 0);
    idle(2);
    chk(bus_valid == 0, "R9 refused flush starts nothing", {31'd0, bus_valid}, 32'd0);
    cfg_user_ok = 1;
    access(0, 32'hE000_000C, 32'h5555_0003);
    xlat_en = 1; req_priv = 1; page_ok = 0;
    access(0, 32'hE000_0010, 32'hBAD0_0004);
    page_ok = 1; req_priv = 0; cfg_user_ok = 0;
    access(0, 32'hE000_0014, 32'h6666_0005);
    xlat_en = 0; req_priv = 1;
    set_pfx(0, 6'h3F);
    access(1, 32'hE000_0000, 0);
    idle(12);
    access(1, 32'hE000_0020, 0);
    idle(12);
    chk(bus_valid == 0 && req_stall == 0, "R5 idle after bursts", {30'd0, bus_valid, req_stall}, 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule